// File: doc/BRIEF.md
# Merging Posted Write Buffer

This block holds memory writes in front of the DRAM sequencer so that each writer is released at once and the data reaches memory later. Three writers feed it: the processor, which writes one doubleword at a time with byte enables; the second-level cache, which writes back whole quadwords; and the PCI bus, which writes quadwords with byte enables. Each write takes one quadword entry. Entries leave through a valid/ready drain port in the order they arrived.

Processor writes get two extra services. A processor doubleword that lands in a quadword already held in the buffer is folded into that entry byte by byte, so it takes no new slot. Processor quadwords that follow one another inside a four-quadword line are presented to the sequencer as one burst, with a last-beat marker. The host writers share a base depth of five quadwords. PCI writes may also use one extra line of four quadwords, which gives nine quadwords (eighteen doublewords). A read-hazard port reports whether a quadword address is still buffered, so a reader can wait until it has drained.

Top module: `merge_write_buffer`

## Requirements
- R1: After synchronous reset, `empty` is 1, `full_host` and `full_pci` are 0, and `drain_valid` is 0.
- R2: Entries leave the drain port in allocation order. Each shows its quadword address, data and byte enables, and is removed when `drain_valid` and `drain_ready` are both high at a rising edge.
- R3: A writeback, or a processor write that does not merge, is accepted only while fewer than 5 entries are held. With 5 or more held, `full_host` is 1 and such a requester sees its stall high in the same cycle.
- R4: A PCI write is accepted while fewer than 9 entries are held. With 9 held, `full_pci` is 1 and a PCI requester is stalled in the same cycle.
- R5: At most one write is taken per cycle, by fixed priority: writeback first, then processor, then PCI, counted among the requesters that are eligible. A requester that is valid but not taken has its stall high. A higher-priority requester that is ineligible does not block a lower one.
- R6: A processor doubleword address is a quadword address followed by one select bit (bit 0). Select 1 places the data and enables in the upper half of the quadword (bytes 4 to 7), and select 0 places them in the lower half. Drain byte enable bit i covers drain data bits 8i+7 to 8i.
- R7: A processor write whose quadword address matches the youngest held entry merges into that entry, unless that entry is being removed in the same cycle. The merge replaces only the enabled bytes, ORs in the enables and allocates nothing. It is accepted even while `full_host` is 1.
- R8: A processor write to the head entry's address, in a cycle where the head is removed, allocates a new entry instead of merging.
- R9: `drain_last` is 0 when the head and the next entry both come from the processor, the next address is the head address plus one, and the head's quadword index within its line (address bits 1:0) is not 3. Otherwise it is 1.
- R10: A writeback entry drains with all eight byte enables set.
- R11: `rd_chk_hit` is 1 exactly when some held entry has quadword address `rd_chk_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_wr_valid | input | 1 | Cache writeback request |
| wb_wr_addr | input | 15 | Writeback quadword address |
| wb_wr_data | input | 64 | Writeback data |
| wb_wr_stall | output | 1 | Writeback not accepted this cycle |
| cpu_wr_valid | input | 1 | Processor write request |
| cpu_wr_addr | input | 16 | Processor doubleword address |
| cpu_wr_data | input | 32 | Processor data |
| cpu_wr_be | input | 4 | Processor byte enables |
| cpu_wr_stall | output | 1 | Processor write not accepted this cycle |
| pci_wr_valid | input | 1 | PCI write request |
| pci_wr_addr | input | 15 | PCI quadword address |
| pci_wr_data | input | 64 | PCI data |
| pci_wr_be | input | 8 | PCI byte enables |
| pci_wr_stall | output | 1 | PCI write not accepted this cycle |
| drain_valid | output | 1 | Head entry presented |
| drain_ready | input | 1 | Sequencer takes head entry |
| drain_addr | output | 15 | Head quadword address |
| drain_data | output | 64 | Head data |
| drain_be | output | 8 | Head byte enables |
| drain_last | output | 1 | Head ends a burst |
| rd_chk_addr | input | 15 | Quadword address to check for a hazard |
| rd_chk_hit | output | 1 | Address is still buffered |
| full_host | output | 1 | Host depth reached |
| full_pci | output | 1 | Total depth reached |
| empty | output | 1 | No entries held |

## Verification
A processor merge and a head removal can fall in the same cycle and aim at the same entry. The bench provokes this by holding `drain_ready` high while the processor writes to the head's address, both in a directed case and often under random traffic over a small address range. It judges the result by the entries that drain next. A second collision, where PCI is granted while the host writers are stalled on capacity, is driven by filling the buffer to five and requesting from all three ports at once.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

    localparam int DW_ADDR_W = 16;
    localparam int QADDR_W   = DW_ADDR_W - 1;
    localparam int DATA_W    = 64;
    localparam int BE_W      = DATA_W / 8;

    typedef enum logic [1:0] {
        SRC_CPU = 2'd0,
        SRC_WB  = 2'd1,
        SRC_PCI = 2'd2
    } src_e;

    typedef struct packed {
        logic [QADDR_W-1:0] addr;
        logic [DATA_W-1:0]  data;
        logic [BE_W-1:0]    be;
        src_e               src;
    } entry_t;

    function automatic int unsigned ring_step(int unsigned p, int unsigned k, int unsigned n);
        int unsigned s;
        s = p + k;
        return (s >= n) ? s - n : s;
    endfunction

endpackage

// File: rtl/pwb_arbiter.sv
module pwb_arbiter (
    input  logic clk,
    input  logic rst,
    input  logic wb_req,
    input  logic cpu_req,
    input  logic pci_req,
    input  logic cpu_merge,
    input  logic host_room,
    input  logic pci_room,
    output logic grant_wb,
    output logic grant_cpu,
    output logic grant_pci
);
    logic wb_ok, cpu_ok, pci_ok;

    always_comb begin
        wb_ok     = wb_req && host_room;
        cpu_ok    = cpu_req && (cpu_merge || host_room);
        pci_ok    = pci_req && pci_room;
        grant_wb  = wb_ok;
        grant_cpu = cpu_ok && !wb_ok;
        grant_pci = pci_ok && !wb_ok && !cpu_ok;
    end

    // R5: one write per cycle
    p_single_grant_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({grant_wb, grant_cpu, grant_pci}));

endmodule

// File: rtl/pwb_match.sv
module pwb_match
    import pwb_pkg::*;
#(
    parameter int N     = 9,
    parameter int PTR_W = 4,
    parameter int CNT_W = 4
) (
    input  entry_t             entries [N],
    input  logic [PTR_W-1:0]   rd_ptr,
    input  logic [CNT_W-1:0]   count,
    input  logic [QADDR_W-1:0] cpu_qaddr,
    input  logic               pop_now,
    input  logic [QADDR_W-1:0] chk_addr,
    output logic               merge_hit,
    output logic [PTR_W-1:0]   merge_idx,
    output logic               chk_hit
);
    logic found, youngest_is_head;

    always_comb begin
        found            = 1'b0;
        youngest_is_head = 1'b0;
        merge_idx        = '0;
        chk_hit          = 1'b0;
        for (int k = 0; k < N; k++) begin
            if (CNT_W'(k) < count) begin
                if (entries[ring_step(int'(rd_ptr), k, N)].addr == cpu_qaddr) begin
                    found            = 1'b1;
                    youngest_is_head = (k == 0);
                    merge_idx        = PTR_W'(ring_step(int'(rd_ptr), k, N));
                end
                if (entries[ring_step(int'(rd_ptr), k, N)].addr == chk_addr)
                    chk_hit = 1'b1;
            end
        end
        merge_hit = found && !(youngest_is_head && pop_now);
    end

endmodule

// File: rtl/pwb_queue.sv
module pwb_queue
    import pwb_pkg::*;
#(
    parameter int N       = 9,
    parameter int BASE    = 5,
    parameter int LINE_QW = 4,
    parameter int PTR_W   = 4,
    parameter int CNT_W   = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               alloc_valid,
    input  entry_t             alloc_entry,
    input  logic               merge_valid,
    input  logic [PTR_W-1:0]   merge_idx,
    input  logic [DATA_W-1:0]  merge_data,
    input  logic [BE_W-1:0]    merge_be,
    input  logic               pop,
    output entry_t             entries_o [N],
    output logic [PTR_W-1:0]   rd_ptr,
    output logic [CNT_W-1:0]   count,
    output entry_t             head,
    output logic               head_last
);
    localparam int LQ_W = $clog2(LINE_QW);

    entry_t           mem [N];
    logic [PTR_W-1:0] wr_ptr;
    entry_t           nxt;

    assign entries_o = mem;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (alloc_valid) wr_ptr <= PTR_W'(ring_step(int'(wr_ptr), 1, N));
            if (pop)         rd_ptr <= PTR_W'(ring_step(int'(rd_ptr), 1, N));
            count <= count + CNT_W'(alloc_valid) - CNT_W'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (alloc_valid) mem[wr_ptr] <= alloc_entry;
        if (merge_valid) begin
            for (int b = 0; b < BE_W; b++)
                if (merge_be[b]) mem[merge_idx].data[8*b +: 8] <= merge_data[8*b +: 8];
            mem[merge_idx].be <= mem[merge_idx].be | merge_be;
        end
    end

    always_comb begin
        head      = mem[rd_ptr];
        nxt       = mem[ring_step(int'(rd_ptr), 1, N)];
        head_last = 1'b1;
        if (count >= CNT_W'(2) && head.src == SRC_CPU && nxt.src == SRC_CPU &&
            head.addr[LQ_W-1:0] != {LQ_W{1'b1}} &&
            nxt.addr == head.addr + QADDR_W'(1))
            head_last = 1'b0;
    end

    // R4: never allocate beyond the total depth
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
        alloc_valid |-> count < CNT_W'(N));
    // R3: host writers stay inside the base depth
    p_host_depth_r3: assert property (@(posedge clk) disable iff (rst)
        (alloc_valid && alloc_entry.src != SRC_PCI) |-> count < CNT_W'(BASE));
    // R2: removal only from a non-empty buffer
    p_no_underflow_r2: assert property (@(posedge clk) disable iff (rst)
        pop |-> count != '0);
    // R7: a merge and an allocation never share a cycle
    p_merge_xor_alloc_r7: assert property (@(posedge clk) disable iff (rst)
        !(merge_valid && alloc_valid));

endmodule

// File: rtl/merge_write_buffer.sv
module merge_write_buffer
    import pwb_pkg::*;
#(
    parameter int BASE_QW = 5,
    parameter int LINE_QW = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wb_wr_valid,
    input  logic [QADDR_W-1:0]   wb_wr_addr,
    input  logic [DATA_W-1:0]    wb_wr_data,
    output logic                 wb_wr_stall,
    input  logic                 cpu_wr_valid,
    input  logic [DW_ADDR_W-1:0] cpu_wr_addr,
    input  logic [31:0]          cpu_wr_data,
    input  logic [3:0]           cpu_wr_be,
    output logic                 cpu_wr_stall,
    input  logic                 pci_wr_valid,
    input  logic [QADDR_W-1:0]   pci_wr_addr,
    input  logic [DATA_W-1:0]    pci_wr_data,
    input  logic [BE_W-1:0]      pci_wr_be,
    output logic                 pci_wr_stall,
    output logic                 drain_valid,
    input  logic                 drain_ready,
    output logic [QADDR_W-1:0]   drain_addr,
    output logic [DATA_W-1:0]    drain_data,
    output logic [BE_W-1:0]      drain_be,
    output logic                 drain_last,
    input  logic [QADDR_W-1:0]   rd_chk_addr,
    output logic                 rd_chk_hit,
    output logic                 full_host,
    output logic                 full_pci,
    output logic                 empty
);
    localparam int N     = BASE_QW + LINE_QW;
    localparam int PTR_W = $clog2(N);
    localparam int CNT_W = $clog2(N + 1);

    entry_t             entries [N];
    entry_t             head, alloc_entry;
    logic [PTR_W-1:0]   rd_ptr, merge_idx;
    logic [CNT_W-1:0]   count;
    logic [QADDR_W-1:0] cpu_qaddr;
    logic [DATA_W-1:0]  cpu_data64;
    logic [BE_W-1:0]    cpu_be8;
    logic               merge_hit, pop, alloc_valid, merge_valid, head_last;
    logic               grant_wb, grant_cpu, grant_pci;

    assign cpu_qaddr  = cpu_wr_addr[DW_ADDR_W-1:1];
    assign cpu_data64 = cpu_wr_addr[0] ? {cpu_wr_data, 32'h0} : {32'h0, cpu_wr_data};
    assign cpu_be8    = cpu_wr_addr[0] ? {cpu_wr_be, 4'h0}   : {4'h0, cpu_wr_be};

    assign empty       = (count == '0);
    assign full_host   = (count >= CNT_W'(BASE_QW));
    assign full_pci    = (count == CNT_W'(N));
    assign drain_valid = !empty;
    assign pop         = drain_valid && drain_ready;

    pwb_match #(.N(N), .PTR_W(PTR_W), .CNT_W(CNT_W)) i_match (
        .entries   (entries),
        .rd_ptr    (rd_ptr),
        .count     (count),
        .cpu_qaddr (cpu_qaddr),
        .pop_now   (pop),
        .chk_addr  (rd_chk_addr),
        .merge_hit (merge_hit),
        .merge_idx (merge_idx),
        .chk_hit   (rd_chk_hit)
    );

    pwb_arbiter i_arb (
        .clk       (clk),
        .rst       (rst),
        .wb_req    (wb_wr_valid),
        .cpu_req   (cpu_wr_valid),
        .pci_req   (pci_wr_valid),
        .cpu_merge (merge_hit),
        .host_room (!full_host),
        .pci_room  (!full_pci),
        .grant_wb  (grant_wb),
        .grant_cpu (grant_cpu),
        .grant_pci (grant_pci)
    );

    assign wb_wr_stall  = wb_wr_valid  && !grant_wb;
    assign cpu_wr_stall = cpu_wr_valid && !grant_cpu;
    assign pci_wr_stall = pci_wr_valid && !grant_pci;

    assign merge_valid = grant_cpu && merge_hit;
    assign alloc_valid = grant_wb || grant_pci || (grant_cpu && !merge_hit);

    always_comb begin
        if (grant_wb)
            alloc_entry = '{addr: wb_wr_addr, data: wb_wr_data, be: {BE_W{1'b1}}, src: SRC_WB};
        else if (grant_cpu)
            alloc_entry = '{addr: cpu_qaddr, data: cpu_data64, be: cpu_be8, src: SRC_CPU};
        else
            alloc_entry = '{addr: pci_wr_addr, data: pci_wr_data, be: pci_wr_be, src: SRC_PCI};
    end

    pwb_queue #(.N(N), .BASE(BASE_QW), .LINE_QW(LINE_QW), .PTR_W(PTR_W), .CNT_W(CNT_W)) i_queue (
        .clk         (clk),
        .rst         (rst),
        .alloc_valid (alloc_valid),
        .alloc_entry (alloc_entry),
        .merge_valid (merge_valid),
        .merge_idx   (merge_idx),
        .merge_data  (cpu_data64),
        .merge_be    (cpu_be8),
        .pop         (pop),
        .entries_o   (entries),
        .rd_ptr      (rd_ptr),
        .count       (count),
        .head        (head),
        .head_last   (head_last)
    );

    assign drain_addr = head.addr;
    assign drain_data = head.data;
    assign drain_be   = head.be;
    assign drain_last = head_last;

    // R3: host requester stalled while host depth is reached
    p_wb_stall_full_r3: assert property (@(posedge clk) disable iff (rst)
        (wb_wr_valid && full_host) |-> wb_wr_stall);
    // R4: PCI requester stalled at total depth
    p_pci_stall_full_r4: assert property (@(posedge clk) disable iff (rst)
        (pci_wr_valid && full_pci) |-> pci_wr_stall);
    // R2: a presented head keeps its address until taken
    p_head_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (drain_valid && !drain_ready) |=> (drain_valid && $stable(drain_addr)));
    // R8: no merge into the entry leaving this cycle
    p_no_merge_popping_r8: assert property (@(posedge clk) disable iff (rst)
        (merge_valid && pop) |-> merge_idx != rd_ptr);

endmodule

// File: tb/test_merge_write_buffer.sv
module test_merge_write_buffer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wb_v = 0, cpu_v = 0, pci_v = 0, rdy = 0;
    logic [14:0] wb_a = 0, pci_a = 0, rd_a = 0;
    logic [63:0] wb_d = 0, pci_d = 0;
    logic [15:0] cpu_a = 0;
    logic [31:0] cpu_d = 0;
    logic [3:0]  cpu_be = 0;
    logic [7:0]  pci_be = 0;

    logic        wb_st, cpu_st, pci_st, d_v, d_last, hit, f_h, f_p, emp;
    logic [14:0] d_a;
    logic [63:0] d_d;
    logic [7:0]  d_be;

    int n_run = 0, n_bad = 0;
    string cur_tag = "R2";

    logic [14:0] maddr [16];
    logic [63:0] mdata [16];
    logic [7:0]  mbe   [16];
    int          msrc  [16];
    int          mc = 0;

    always #4 clk = ~clk;

    merge_write_buffer i_merge_write_buffer (
        .clk(clk), .rst(rst),
        .wb_wr_valid(wb_v), .wb_wr_addr(wb_a), .wb_wr_data(wb_d), .wb_wr_stall(wb_st),
        .cpu_wr_valid(cpu_v), .cpu_wr_addr(cpu_a), .cpu_wr_data(cpu_d), .cpu_wr_be(cpu_be),
        .cpu_wr_stall(cpu_st),
        .pci_wr_valid(pci_v), .pci_wr_addr(pci_a), .pci_wr_data(pci_d), .pci_wr_be(pci_be),
        .pci_wr_stall(pci_st),
        .drain_valid(d_v), .drain_ready(rdy), .drain_addr(d_a), .drain_data(d_d),
        .drain_be(d_be), .drain_last(d_last),
        .rd_chk_addr(rd_a), .rd_chk_hit(hit),
        .full_host(f_h), .full_pci(f_p), .empty(emp)
    );

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic exp_last();
        if (mc < 2) return 1'b1;
        if (msrc[0] != 0 || msrc[1] != 0) return 1'b1;
        if (maddr[0][1:0] == 2'b11) return 1'b1;
        return (maddr[1] == maddr[0] + 15'd1) ? 1'b0 : 1'b1;
    endfunction

    function automatic logic exp_hit(input logic [14:0] a);
        for (int j = 0; j < mc; j++) if (maddr[j] == a) return 1'b1;
        return 1'b0;
    endfunction

    // one cycle: inputs are already driven at the falling edge
    task automatic step();
        logic [14:0] cq;
        logic [63:0] cd;
        logic [7:0]  cb;
        int  mj;
        logic mhit, popx, wbok, cpuok, pciok, gw, gc, gp;
        #2;
        cq = cpu_a[15:1];
        cd = cpu_a[0] ? {cpu_d, 32'h0} : {32'h0, cpu_d};
        cb = cpu_a[0] ? {cpu_be, 4'h0} : {4'h0, cpu_be};
        mj = -1;
        for (int j = 0; j < mc; j++) if (maddr[j] == cq) mj = j;
        mhit  = (mj >= 0) && !(mj == 0 && rdy);
        popx  = (mc > 0) && rdy;
        wbok  = wb_v && mc < 5;
        cpuok = cpu_v && (mhit || mc < 5);
        pciok = pci_v && mc < 9;
        gw = wbok; gc = cpuok && !wbok; gp = pciok && !wbok && !cpuok;

        chk((wb_v && mc >= 5) ? "R3" : "R5", "wb_stall", 64'(wb_st), 64'(wb_v && !gw));
        chk((cpu_v && mhit) ? "R7" : ((cpu_v && mc >= 5) ? "R3" : "R5"), "cpu_stall",
            64'(cpu_st), 64'(cpu_v && !gc));
        chk((pci_v && mc >= 9) ? "R4" : "R5", "pci_stall", 64'(pci_st), 64'(pci_v && !gp));
        chk("R1", "empty", 64'(emp), 64'(mc == 0));
        chk("R3", "full_host", 64'(f_h), 64'(mc >= 5));
        chk("R4", "full_pci", 64'(f_p), 64'(mc == 9));
        chk("R2", "drain_valid", 64'(d_v), 64'(mc > 0));
        chk("R11", "rd_chk_hit", 64'(hit), 64'(exp_hit(rd_a)));
        if (mc > 0) begin
            chk(cur_tag, "drain_addr", 64'(d_a), 64'(maddr[0]));
            chk(cur_tag, "drain_data", d_d, mdata[0]);
            chk(cur_tag, "drain_be", 64'(d_be), 64'(mbe[0]));
            chk((cur_tag == "R2") ? "R9" : cur_tag, "drain_last", 64'(d_last), 64'(exp_last()));
        end
        @(posedge clk);
        if (gc && mhit) begin
            for (int b = 0; b < 8; b++) if (cb[b]) mdata[mj][8*b +: 8] = cd[8*b +: 8];
            mbe[mj] = mbe[mj] | cb;
        end
        if (popx) begin
            for (int j = 0; j < 15; j++) begin
                maddr[j] = maddr[j+1]; mdata[j] = mdata[j+1]; mbe[j] = mbe[j+1]; msrc[j] = msrc[j+1];
            end
            mc--;
        end
        if (gw) begin
            maddr[mc] = wb_a; mdata[mc] = wb_d; mbe[mc] = 8'hFF; msrc[mc] = 1; mc++;
        end else if (gc && !mhit) begin
            maddr[mc] = cq; mdata[mc] = cd; mbe[mc] = cb; msrc[mc] = 0; mc++;
        end else if (gp) begin
            maddr[mc] = pci_a; mdata[mc] = pci_d; mbe[mc] = pci_be; msrc[mc] = 2; mc++;
        end
        @(negedge clk);
    endtask

    task automatic idle();
        wb_v = 0; cpu_v = 0; pci_v = 0;
    endtask

    task automatic cpu_wr(input logic [15:0] a, input logic [31:0] d, input logic [3:0] be);
        idle(); cpu_v = 1; cpu_a = a; cpu_d = d; cpu_be = be; step(); idle();
    endtask

    task automatic drain_all();
        idle(); rdy = 1;
        for (int i = 0; i < 40 && mc > 0; i++) step();
        step();
    endtask

    initial begin
        #(8 * 200000);
        n_run++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7741));
        repeat (3) @(negedge clk);
        rst = 0;
        #2;
        chk("R1", "reset empty", 64'(emp), 64'd1);
        chk("R1", "reset full_host", 64'(f_h), 64'd0);
        chk("R1", "reset full_pci", 64'(f_p), 64'd0);
        chk("R1", "reset drain_valid", 64'(d_v), 64'd0);
        @(negedge clk);

        // R6 placement, R7 merge into a held quadword
        rdy = 0; cur_tag = "R6";
        cpu_wr(16'h0020, 32'h1122_3344, 4'hF);
        cur_tag = "R7";
        cpu_wr(16'h0021, 32'hAABB_CCDD, 4'h5);
        cpu_wr(16'h0020, 32'h0000_9900, 4'h2);
        #2;
        chk("R6", "upper half bytes", d_d, 64'h00BB_00DD_1122_9944);
        chk("R7", "merged enables", 64'(d_be), 64'h5F);
        @(negedge clk);
        // R8: write to the head while it leaves
        cur_tag = "R8";
        rdy = 1;
        cpu_wr(16'h0020, 32'h5555_6666, 4'h3);
        rdy = 0; step();
        drain_all();

        // R9 bursts inside one line
        rdy = 0; cur_tag = "R9";
        for (int i = 0; i < 5; i++) cpu_wr(16'h0040 + 16'(2*i), 32'hC0DE_0000 + 32'(i), 4'hF);
        drain_all();

        // R10 writeback enables
        cur_tag = "R10"; rdy = 0;
        idle(); wb_v = 1; wb_a = 15'h0030; wb_d = 64'hFEED_FACE_0123_4567; step(); idle();
        drain_all();

        // R3/R4/R5 capacity and priority corners
        cur_tag = "R2"; rdy = 0;
        for (int i = 0; i < 6; i++) begin
            idle(); wb_v = 1; wb_a = 15'h0100 + 15'(i); wb_d = 64'(i) * 64'h0101; step();
        end
        idle(); wb_v = 1; wb_a = 15'h0200; cpu_v = 1; cpu_a = 16'h0600; cpu_d = 32'h1;
        cpu_be = 4'hF; pci_v = 1; pci_a = 15'h0300; pci_d = 64'h77; pci_be = 8'h0F;
        step();
        idle();
        for (int i = 0; i < 4; i++) begin
            pci_v = 1; pci_a = 15'h0310 + 15'(i); pci_d = 64'h1000 + 64'(i); pci_be = 8'hF0; step();
        end
        idle();
        cur_tag = "R7";
        cpu_v = 1; cpu_a = 16'h0202; cpu_d = 32'hDEAD_BEEF; cpu_be = 4'hC; step(); idle();
        rd_a = 15'h0312; step();
        rd_a = 15'h0555; step();
        cur_tag = "R2";
        drain_all();

        // random traffic over a narrow range
        for (int c = 0; c < 4000; c++) begin
            wb_v  = ($urandom_range(0, 99) < 15);
            wb_a  = 15'($urandom_range(0, 7));
            wb_d  = {$urandom, $urandom};
            cpu_v = ($urandom_range(0, 99) < 45);
            cpu_a = 16'($urandom_range(0, 15));
            cpu_d = $urandom;
            cpu_be = 4'($urandom_range(0, 15));
            pci_v = ($urandom_range(0, 99) < 30);
            pci_a = 15'($urandom_range(0, 7));
            pci_d = {$urandom, $urandom};
            pci_be = 8'($urandom_range(0, 255));
            rdy   = ($urandom_range(0, 99) < 40);
            rd_a  = 15'($urandom_range(0, 9));
            step();
        end
        drain_all();

        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

endmodule